// File: doc/BRIEF.md
# Burst Read Responder with Decode Error

This block answers read bursts aimed at a small on-chip memory window. A requester presents a start address, a beat count, a transfer size and a burst type on a valid/ready request port. The block works out the address of each beat, aligns it down to the transfer size, looks it up, and returns one data beat per address on a valid/ready beat port. The final beat carries a last flag.

Beats whose address lies outside the memory window return zero data with a decode-error response. A per-request flag selects consistent-error handling. With the flag set, the block first visits every beat address of the burst before it sends anything, and if any beat misses, every beat of that burst reports decode error. The memory is read-only. Its contents are a fixed function of the byte offset, so data can be predicted without a load path.

Top module: `burst_read_responder`

## Requirements
- R1: After reset, `req_ready` is high and `beat_valid` is low.
- R2: A burst with length field L yields exactly L+1 beats, and `beat_last` is high only on the final one. `req_ready` is low from the acceptance edge until the last beat is taken, and high again in the cycle after that.
- R3: A beat spans 2^S bytes for size field S. A size larger than the bus width (4 bytes by default) is treated as the full bus width.
- R4: Each beat address has its low S bits cleared before lookup.
- R5: Burst type 0 (fixed) repeats the aligned start address. Type 1 (incrementing) adds 2^S per beat. Type 2 (wrapping) stays inside an aligned window of (L+1)·2^S bytes. The reserved type 3 behaves as incrementing.
- R6: A beat whose address lies in [BASE, BASE + 4·WORDS) responds 0 (OKAY). The memory byte at address BASE+k holds (k mod 256) XOR 0x5A. Each byte sits on lane (address mod 4), and lanes outside the beat are zero.
- R7: A beat whose address falls outside the window has all-zero data and response 3 (decode error).
- R8: With consistent-error mode set, if any beat of the burst misses, every beat of that burst reports response 3. Beats that hit still carry their data.
- R9: Without consistent mode, the first beat is valid in the cycle after acceptance. With it, the first beat is valid L+1 cycles after that.
- R10: While `beat_valid` is high and `beat_ready` is low, data, response and last stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Beat count minus one |
| req_size | input | SIZE_W | log2 of bytes per beat |
| req_burst | input | 2 | 0 fixed, 1 incrementing, 2 wrapping, 3 as incrementing |
| req_all_err | input | 1 | Consistent-error mode for this burst |
| beat_valid | output | 1 | Beat present |
| beat_ready | input | 1 | Beat taken by the consumer |
| beat_data | output | DATA_W | Beat data on its byte lanes |
| beat_resp | output | 2 | 0 OKAY, 3 decode error |
| beat_last | output | 1 | Final beat of the burst |

## Verification
A request is taken on the rising edge at which `req_valid` and `req_ready` are both high. Beat outputs are combinational from registered state, so without consistent mode the first beat can be seen on the falling edge just after acceptance. In consistent mode it appears only after L+1 further scan edges. The bench drives on falling edges and samples there. For each burst it counts the falling edges with `beat_valid` low before the first beat, and compares that count with 0 or L+1. The beat taken on a rising edge is followed on the next falling edge either by the following beat or, after the last beat, by `req_ready` high. Stalled beats are compared across consecutive falling edges.

// File: rtl/brr_pkg.sv
package brr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_SEND = 2'd2
    } brr_state_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_DECERR = 2'b11;

    localparam logic [1:0] BT_FIXED = 2'd0;
    localparam logic [1:0] BT_INCR  = 2'd1;
    localparam logic [1:0] BT_WRAP  = 2'd2;
endpackage

// File: rtl/brr_addr_gen.sv
// Beat address for beat number idx of a burst, already aligned to the size.
module brr_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 4,
    parameter int SIZE_W = 2
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [SIZE_W-1:0] size,
    input  logic [1:0]        burst,
    input  logic [LEN_W-1:0]  idx,
    output logic [ADDR_W-1:0] beat_addr
);
    import brr_pkg::*;

    logic [ADDR_W-1:0] size_mask;
    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] span_mask;
    logic [ADDR_W-1:0] linear;

    always_comb begin
        size_mask = (ADDR_W'(1) << size) - ADDR_W'(1);
        aligned   = start_addr & ~size_mask;
        step      = ADDR_W'(idx) << size;
        span_mask = ((ADDR_W'(len) + ADDR_W'(1)) << size) - ADDR_W'(1);
        linear    = aligned + step;
        case (burst)
            BT_FIXED: beat_addr = aligned;
            BT_WRAP:  beat_addr = (aligned & ~span_mask) | (linear & span_mask);
            default:  beat_addr = linear;
        endcase
    end
endmodule

// File: rtl/brr_decode.sv
// Window check and split of a byte address into word index and lane offset.
module brr_decode #(
    parameter int          ADDR_W    = 16,
    parameter int          BYTES     = 4,
    parameter int          WORDS     = 64,
    parameter int unsigned BASE_ADDR = 32'h1000,
    localparam int         OFF_W     = $clog2(BYTES),
    localparam int         WIDX_W    = $clog2(WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [WIDX_W-1:0] word_idx,
    output logic [OFF_W-1:0]  lane_off
);
    localparam logic [ADDR_W:0] LOW_X  = (ADDR_W+1)'(BASE_ADDR);
    localparam logic [ADDR_W:0] HIGH_X = (ADDR_W+1)'(BASE_ADDR + WORDS * BYTES);

    logic [ADDR_W-1:0] rel;

    always_comb begin
        hit      = ({1'b0, addr} >= LOW_X) && ({1'b0, addr} < HIGH_X);
        rel      = addr - ADDR_W'(BASE_ADDR);
        word_idx = WIDX_W'(rel >> OFF_W);
        lane_off = addr[OFF_W-1:0];
    end
endmodule

// File: rtl/brr_store.sv
// Read-only word store with computed contents and byte-lane masking.
module brr_store #(
    parameter int  DATA_W = 32,
    parameter int  WORDS  = 64,
    parameter int  SIZE_W = 2,
    localparam int BYTES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(BYTES),
    localparam int WIDX_W = $clog2(WORDS)
) (
    input  logic [WIDX_W-1:0] word_idx,
    input  logic [OFF_W-1:0]  lane_off,
    input  logic [SIZE_W-1:0] size,
    output logic [DATA_W-1:0] lane_data
);
    for (genvar j = 0; j < BYTES; j++) begin : g_lane
        logic [WIDX_W+OFF_W-1:0] byte_off;
        logic                    lane_on;
        always_comb begin
            byte_off = {word_idx, OFF_W'(j)};
            lane_on  = (j >= int'(lane_off)) && (j < int'(lane_off) + (1 << size));
            lane_data[8*j +: 8] = lane_on ? (8'(byte_off) ^ 8'h5A) : 8'h00;
        end
    end
endmodule

// File: rtl/burst_read_responder.sv
module burst_read_responder #(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 32,
    parameter int          LEN_W     = 4,
    parameter int          SIZE_W    = 2,
    parameter int unsigned BASE_ADDR = 32'h1000,
    parameter int          WORDS     = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [1:0]        req_burst,
    input  logic              req_all_err,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [DATA_W-1:0] beat_data,
    output logic [1:0]        beat_resp,
    output logic              beat_last
);
    import brr_pkg::*;

    localparam int BYTES    = DATA_W / 8;
    localparam int OFF_W    = $clog2(BYTES);
    localparam int WIDX_W   = $clog2(WORDS);
    localparam int MAX_SIZE = OFF_W;

    typedef struct packed {
        brr_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [SIZE_W-1:0] size;
        logic [1:0]        burst;
        logic              all_err;
        logic [LEN_W-1:0]  idx;
        logic              miss_seen;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [ADDR_W-1:0] cur_addr;
    logic              cur_hit;
    logic [WIDX_W-1:0] cur_word;
    logic [OFF_W-1:0]  cur_lane;
    logic [DATA_W-1:0] cur_data;
    logic [SIZE_W-1:0] size_eff;
    logic              at_end;

    brr_addr_gen #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .SIZE_W (SIZE_W)
    ) u_addr (
        .start_addr (ctx_q.addr),
        .len        (ctx_q.len),
        .size       (ctx_q.size),
        .burst      (ctx_q.burst),
        .idx        (ctx_q.idx),
        .beat_addr  (cur_addr)
    );

    brr_decode #(
        .ADDR_W    (ADDR_W),
        .BYTES     (BYTES),
        .WORDS     (WORDS),
        .BASE_ADDR (BASE_ADDR)
    ) u_dec (
        .addr     (cur_addr),
        .hit      (cur_hit),
        .word_idx (cur_word),
        .lane_off (cur_lane)
    );

    brr_store #(
        .DATA_W (DATA_W),
        .WORDS  (WORDS),
        .SIZE_W (SIZE_W)
    ) u_store (
        .word_idx  (cur_word),
        .lane_off  (cur_lane),
        .size      (ctx_q.size),
        .lane_data (cur_data)
    );

    always_comb begin
        ctx_d    = ctx_q;
        size_eff = (req_size > SIZE_W'(MAX_SIZE)) ? SIZE_W'(MAX_SIZE) : req_size;
        at_end   = (ctx_q.idx == ctx_q.len);

        req_ready  = (ctx_q.state == ST_IDLE);
        beat_valid = (ctx_q.state == ST_SEND);
        beat_last  = beat_valid && at_end;
        beat_data  = cur_hit ? cur_data : '0;
        beat_resp  = (cur_hit && !(ctx_q.all_err && ctx_q.miss_seen)) ? RESP_OKAY : RESP_DECERR;

        case (ctx_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.addr      = req_addr;
                    ctx_d.len       = req_len;
                    ctx_d.size      = size_eff;
                    ctx_d.burst     = req_burst;
                    ctx_d.all_err   = req_all_err;
                    ctx_d.idx       = '0;
                    ctx_d.miss_seen = 1'b0;
                    ctx_d.state     = req_all_err ? ST_SCAN : ST_SEND;
                end
            end
            ST_SCAN: begin
                ctx_d.miss_seen = ctx_q.miss_seen | ~cur_hit;
                if (at_end) begin
                    ctx_d.idx   = '0;
                    ctx_d.state = ST_SEND;
                end else begin
                    ctx_d.idx = ctx_q.idx + LEN_W'(1);
                end
            end
            ST_SEND: begin
                if (beat_ready) begin
                    if (at_end) begin
                        ctx_d.state = ST_IDLE;
                    end else begin
                        ctx_d.idx = ctx_q.idx + LEN_W'(1);
                    end
                end
            end
            default: ctx_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{state: ST_IDLE, default: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end
endmodule

// File: rtl/brr_chk.sv
module brr_chk #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [LEN_W-1:0]  req_len,
    input logic              req_all_err,
    input logic              beat_valid,
    input logic              beat_ready,
    input logic [DATA_W-1:0] beat_data,
    input logic [1:0]        beat_resp,
    input logic              beat_last
);
    logic             accept;
    logic             take;
    logic             busy_q;
    logic             cons_q;
    logic             err_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W:0]   beats_q;
    logic [LEN_W+1:0] wait_q;

    assign accept = req_valid && req_ready;
    assign take   = beat_valid && beat_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cons_q  <= 1'b0;
            err_q   <= 1'b0;
            len_q   <= '0;
            beats_q <= '0;
            wait_q  <= '0;
        end else if (accept) begin
            busy_q  <= 1'b1;
            cons_q  <= req_all_err;
            err_q   <= 1'b0;
            len_q   <= req_len;
            beats_q <= '0;
            wait_q  <= '0;
        end else begin
            if (busy_q && !beat_valid && beats_q == '0) wait_q <= wait_q + 1'b1;
            if (take) begin
                beats_q <= beats_q + 1'b1;
                if (beat_resp != 2'b00) err_q <= 1'b1;
                if (beat_last) busy_q <= 1'b0;
            end
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) $rose(rst_n) |-> req_ready && !beat_valid);

    // R2
    busy_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> !req_ready);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    // R2
    last_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && beat_last) |=> req_ready);

    // R2
    beat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_last) |-> (beats_q == {1'b0, len_q}));

    // R7
    resp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (beat_resp == 2'b00 || beat_resp == 2'b11));

    // R8
    sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && cons_q && err_q) |-> (beat_resp == 2'b11));

    // R9
    scan_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beats_q == '0) |-> (wait_q == (cons_q ? ({2'b0, len_q} + 1'b1) : '0)));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready) |=> beat_valid && $stable(beat_data) && $stable(beat_resp) && $stable(beat_last));
endmodule

bind burst_read_responder brr_chk #(
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_len     (req_len),
    .req_all_err (req_all_err),
    .beat_valid  (beat_valid),
    .beat_ready  (beat_ready),
    .beat_data   (beat_data),
    .beat_resp   (beat_resp),
    .beat_last   (beat_last)
);

// File: tb/burst_read_responder_tb.sv
module burst_read_responder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_len = '0;
    logic [1:0]  req_size = '0;
    logic [1:0]  req_burst = '0;
    logic        req_all_err = 1'b0;
    logic        beat_valid;
    logic        beat_ready = 1'b0;
    logic [31:0] beat_data;
    logic [1:0]  beat_resp;
    logic        beat_last;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    burst_read_responder u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .req_len (req_len), .req_size (req_size),
        .req_burst (req_burst), .req_all_err (req_all_err),
        .beat_valid (beat_valid), .beat_ready (beat_ready),
        .beat_data (beat_data), .beat_resp (beat_resp), .beat_last (beat_last)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Model built from the requirements.
    function automatic int m_addr(int a, int len, int size, int bt, int i);
        int sz, nb, al, tot, wb;
        sz = (size > 2) ? 2 : size;
        nb = 1 << sz;
        al = a - (a % nb);
        if (bt == 0) return al;
        if (bt == 2) begin
            tot = (len + 1) * nb;
            wb  = al - (al % tot);
            return wb + ((al - wb + i * nb) % tot);
        end
        return (al + i * nb) & 16'hFFFF;
    endfunction

    function automatic bit m_hit(int a);
        return (a >= 'h1000) && (a < 'h1100);
    endfunction

    function automatic logic [31:0] m_data(int a, int size);
        logic [31:0] d;
        int sz, wb;
        d  = '0;
        sz = (size > 2) ? 2 : size;
        wb = a - (a % 4);
        if (m_hit(a)) begin
            for (int j = 0; j < 4; j++)
                if (j >= a % 4 && j < a % 4 + (1 << sz))
                    d[8*j +: 8] = 8'((wb + j - 'h1000) & 255) ^ 8'h5A;
        end
        return d;
    endfunction

    task automatic run_burst(input int a, input int len, input int size, input int bt,
                             input bit cons, input bit stall, input string tag);
        bit          any_miss;
        bit          held;
        logic [31:0] h_data;
        logic [1:0]  h_resp;
        logic        h_last;
        int          beat, waits, k, ea, exp_wait;
        logic [1:0]  eresp;
        any_miss = 0;
        for (int i = 0; i <= len; i++) if (!m_hit(m_addr(a, len, size, bt, i))) any_miss = 1;
        exp_wait = cons ? len + 1 : 0;
        @(negedge clk);
        req_addr = 16'(a); req_len = 4'(len); req_size = 2'(size);
        req_burst = 2'(bt); req_all_err = cons; req_valid = 1'b1;
        chk(req_ready, "R2", {tag, " idle before request"}, 32'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        beat = 0; waits = 0; k = 0; held = 0;
        while (beat <= len && k < 200) begin
            beat_ready = stall ? (k % 3 == 2) : 1'b1;
            k++;
            if (held) begin
                chk(beat_valid && beat_data == h_data && beat_resp == h_resp && beat_last == h_last,
                    "R10", {tag, " stalled beat held"}, beat_data, h_data);
                held = 0;
            end
            if (!beat_valid) begin
                if (beat == 0) waits++;
            end else begin
                if (beat == 0)
                    chk(waits == exp_wait, "R9", {tag, " first beat delay"}, 32'(waits), 32'(exp_wait));
                chk(!req_ready, "R2", {tag, " busy during burst"}, 32'(req_ready), 0);
                if (beat_ready) begin
                    ea = m_addr(a, len, size, bt, beat);
                    eresp = (!m_hit(ea) || (cons && any_miss)) ? 2'b11 : 2'b00;
                    chk(beat_data == m_data(ea, size), m_hit(ea) ? "R6" : "R7",
                        {tag, " data (R3 R4 R5)"}, beat_data, m_data(ea, size));
                    chk(beat_resp == eresp, cons ? "R8" : "R7", {tag, " response"},
                        32'(beat_resp), 32'(eresp));
                    chk(beat_last == (beat == len), "R2", {tag, " last flag"},
                        32'(beat_last), 32'(beat == len));
                    beat++;
                end else begin
                    held = 1; h_data = beat_data; h_resp = beat_resp; h_last = beat_last;
                end
            end
            @(negedge clk);
        end
        beat_ready = 1'b0;
        chk(beat == len + 1, "R2", {tag, " beat count"}, 32'(beat), 32'(len + 1));
        chk(req_ready && !beat_valid, "R2", {tag, " ready after last beat"}, 32'(req_ready), 1);
    endtask

    task automatic t_reset();
        chk(req_ready && !beat_valid, "R1", "reset idle", {req_ready, beat_valid}, 32'b10);
    endtask

    task automatic t_incr_full();    run_burst('h1000, 3, 2, 1, 0, 0, "incr word");        endtask
    task automatic t_incr_bytes();   run_burst('h1003, 5, 0, 1, 0, 0, "incr byte lanes");  endtask
    task automatic t_align_half();   run_burst('h1005, 2, 1, 1, 0, 0, "R4 half align");    endtask
    task automatic t_fixed_stall();  run_burst('h1013, 2, 1, 0, 0, 1, "R5 fixed stall");   endtask
    task automatic t_wrap();         run_burst('h1038, 3, 2, 2, 0, 1, "R5 wrap");          endtask
    task automatic t_reserved();     run_burst('h1020, 1, 2, 3, 0, 0, "R5 type3 incr");    endtask
    task automatic t_miss_top();     run_burst('h10F8, 3, 2, 1, 0, 0, "R7 miss top");      endtask
    task automatic t_miss_cons();    run_burst('h10F8, 3, 2, 1, 1, 1, "R8 cons miss");     endtask
    task automatic t_cons_clean();   run_burst('h1040, 2, 2, 1, 1, 0, "R9 cons clean");    endtask
    task automatic t_miss_low();     run_burst('h0FFE, 1, 1, 1, 0, 0, "R7 below base");    endtask
    task automatic t_size_clamp();   run_burst('h1011, 1, 3, 1, 0, 0, "R3 size clamp");    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", tests, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_incr_full();
        t_incr_bytes();
        t_align_half();
        t_fixed_stall();
        t_wrap();
        t_reserved();
        t_miss_top();
        t_miss_cons();
        t_cons_clean();
        t_miss_low();
        t_size_clamp();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule